// File: doc/BRIEF.md
# Register Shift Execution Unit

This unit carries out the three register-register shift operations of a RISC-V integer pipeline: shift left logical, shift right logical and shift right arithmetic. It receives the full 32-bit instruction word, both 64-bit source operand values and a run-time width select that chooses between 32-bit and 64-bit operation. From the instruction's major opcode, function-3 and function-7 fields it decides which shift to perform. It returns a 64-bit result, a flag that marks the result as valid, and a flag that marks a reserved shift encoding.

All shift amounts, operand widths and fill rules pass through a single logarithmic barrel shifter. In 32-bit mode only the low word of the first operand takes part. The sixth stage of the shifter is switched off, so only five bits of the second operand give the amount. The 32-bit result is then sign-extended to 64 bits. An optional output register, enabled by default, gives one cycle of latency and has a synchronous active-high reset.

Top module: `shift_unit`

## Requirements
- R1: With major opcode 0110011 (instr bits [6:0]), the unit recognises three encodings and raises `valid_o`. Function-3 (bits [14:12]) 001 with function-7 (bits [31:25]) 0000000 selects the left shift. Function-3 101 with function-7 0000000 selects the logical right shift. Function-3 101 with function-7 0100000 selects the arithmetic right shift.
- R2: Any other function-3/function-7 pair under opcode 0110011 raises `illegal_o`, clears `valid_o` and forces the result to zero.
- R3: Any other major opcode clears both `valid_o` and `illegal_o` and forces the result to zero.
- R4: In 32-bit mode (`rv64_i`=0) the shift amount is `rs2_i[4:0]`, and every higher bit of `rs2_i` is ignored. For example, 32 acts as 0, 33 as 1, 37 as 5 and 63 as 31.
- R5: In 64-bit mode (`rv64_i`=1) the shift amount is `rs2_i[5:0]`. The full 64-bit `rs1_i` is shifted and no sign extension is applied.
- R6: In 32-bit mode only `rs1_i[31:0]` is shifted. Bits [63:32] of the result always copy result bit 31, for all three operations including the logical right shift.
- R7: The logical right shift fills vacated positions with zeros. For example, 0xFFFFFFFF shifted right by 1 gives 0x7FFFFFFF in the low word.
- R8: The arithmetic right shift fills vacated positions with the operand's sign bit: bit 31 in 32-bit mode, bit 63 in 64-bit mode. For example, 0x80000000 shifted by 31 gives all ones in 32-bit mode.
- R9: The left shift discards bits moved past the top of the active width. For example, 0xFFFFFFFF shifted by 1 gives 0xFFFFFFFE in 32-bit mode.
- R10: With the output register enabled, outputs follow the inputs of the previous clock edge. A clock edge with `rst` high drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to decode |
| rs1_i | input | 64 | Value to be shifted |
| rs2_i | input | 64 | Value whose low bits give the shift amount |
| rv64_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| result_o | output | 64 | Shift result, zero when not valid |
| valid_o | output | 1 | Result is a recognised shift |
| illegal_o | output | 1 | Reserved encoding under the register opcode |

## Verification
In 32-bit mode, amount masking and the final sign extension act in the same cycle. A logical right shift by zero of a word with bit 31 set must still extend ones into the upper half, while an amount of 33 must behave as 1 and clear that bit. The bench sweeps all 64 values of the low six amount bits, with random upper bits in `rs2_i`, for each operation and mode. It uses operands whose bit 31 and bit 63 differ and compares every result with an arithmetic model. The checker also asserts that a 32-bit arithmetic shift of a negative word by 31 gives all ones whatever amount bit 5 holds.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam logic [6:0] OPC_REG_ALU = 7'b0110011;
  localparam logic [2:0] F3_LEFT     = 3'b001;
  localparam logic [2:0] F3_RIGHT    = 3'b101;
  localparam logic [6:0] F7_PLAIN    = 7'b0000000;
  localparam logic [6:0] F7_ALT      = 7'b0100000;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2,
    SH_NONE  = 2'd3
  } shop_e;

  typedef struct packed {
    logic [6:0] f7;
    logic [4:0] src2;
    logic [4:0] src1;
    logic [2:0] f3;
    logic [4:0] dst;
    logic [6:0] opc;
  } rtype_t;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  rtype_t instr,
  output shop_e  op,
  output logic   legal,
  output logic   illegal
);

  logic is_reg;

  assign is_reg = (instr.opc == OPC_REG_ALU);

  always_comb begin
    op = SH_NONE;
    if (is_reg) begin
      if (instr.f3 == F3_LEFT && instr.f7 == F7_PLAIN)
        op = SH_LEFT;
      else if (instr.f3 == F3_RIGHT && instr.f7 == F7_PLAIN)
        op = SH_RLOG;
      else if (instr.f3 == F3_RIGHT && instr.f7 == F7_ALT)
        op = SH_RARI;
    end
  end

  assign legal   = (op != SH_NONE);
  assign illegal = is_reg && (op == SH_NONE);

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic [SHW-1:0]  stage_en,
  input  logic            left,
  input  logic            fill,
  output logic [XLEN-1:0] dout
);

  logic [XLEN-1:0] st [SHW+1];

  assign st[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [XLEN-1:0] shl;
    logic [XLEN-1:0] shr;
    assign shl = {st[k][XLEN-D-1:0], {D{1'b0}}};
    assign shr = {{D{fill}}, st[k][XLEN-1:D]};
    assign st[k+1] = !(amt[k] && stage_en[k]) ? st[k] : (left ? shl : shr);
  end

  assign dout = st[SHW];

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2,
  localparam int SHW  = $clog2(XLEN),
  localparam int HSHW = $clog2(HALF)
) (
  input  shop_e           op,
  input  logic            rv64,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] res
);

  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] shifted;
  logic [SHW-1:0]  stage_en;
  logic            fill;
  logic            arith;
  logic            top_bit;

  assign arith   = (op == SH_RARI);
  assign top_bit = rv64 ? src_a[XLEN-1] : src_a[HALF-1];
  assign fill    = arith && top_bit;

  // Narrow mode: only the low half participates; widen by sign for the
  // arithmetic shift so the fill bit enters from the correct place.
  always_comb begin
    if (rv64)
      operand = src_a;
    else if (arith)
      operand = {{HALF{src_a[HALF-1]}}, src_a[HALF-1:0]};
    else
      operand = {{HALF{1'b0}}, src_a[HALF-1:0]};
  end

  for (genvar k = 0; k < SHW; k++) begin : g_en
    if (k < HSHW) begin : g_on
      assign stage_en[k] = 1'b1;
    end else begin : g_mode
      assign stage_en[k] = rv64;
    end
  end

  shift_barrel #(.XLEN(XLEN)) barrel_i (
    .din      (operand),
    .amt      (src_b[SHW-1:0]),
    .stage_en (stage_en),
    .left     (op == SH_LEFT),
    .fill     (fill),
    .dout     (shifted)
  );

  assign res = rv64 ? shifted : {{HALF{shifted[HALF-1]}}, shifted[HALF-1:0]};

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int ILEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic            rv64_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o,
  output logic            illegal_o
);

  shop_e           op;
  logic            legal;
  logic            bad;
  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] res_c;

  shift_decode dec_i (
    .instr   (rtype_t'(instr_i)),
    .op      (op),
    .legal   (legal),
    .illegal (bad)
  );

  shift_datapath #(.XLEN(XLEN)) dp_i (
    .op    (op),
    .rv64  (rv64_i),
    .src_a (rs1_i),
    .src_b (rs2_i),
    .res   (raw)
  );

  assign res_c = legal ? raw : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result_o  <= '0;
        valid_o   <= 1'b0;
        illegal_o <= 1'b0;
      end else begin
        result_o  <= res_c;
        valid_o   <= legal;
        illegal_o <= bad;
      end
    end
  end else begin : g_comb
    assign result_o  = res_c;
    assign valid_o   = legal;
    assign illegal_o = bad;
  end

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int XLEN    = 64,
  parameter int ILEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [ILEN-1:0] instr_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic            rv64_i,
  input logic [XLEN-1:0] result_o,
  input logic            valid_o,
  input logic            illegal_o
);
  localparam int HALF = XLEN / 2;

  logic [ILEN-1:0] d_instr;
  logic [XLEN-1:0] d_rs1;
  logic [XLEN-1:0] d_rs2;
  logic            d_rv64;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) begin
        d_instr <= '0;
        d_rs1   <= '0;
        d_rs2   <= '0;
        d_rv64  <= 1'b0;
      end else begin
        d_instr <= instr_i;
        d_rs1   <= rs1_i;
        d_rs2   <= rs2_i;
        d_rv64  <= rv64_i;
      end
    end
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (result_o == '0 && !valid_o && !illegal_o)); // R10
  end else begin : g_pass
    assign d_instr = instr_i;
    assign d_rs1   = rs1_i;
    assign d_rs2   = rs2_i;
    assign d_rv64  = rv64_i;
  end

  logic reg_opc;
  logic is_sll, is_srl, is_sra;
  assign reg_opc = (d_instr[6:0] == 7'b0110011);
  assign is_sll  = reg_opc && d_instr[14:12] == 3'b001 && d_instr[31:25] == 7'b0000000;
  assign is_srl  = reg_opc && d_instr[14:12] == 3'b101 && d_instr[31:25] == 7'b0000000;
  assign is_sra  = reg_opc && d_instr[14:12] == 3'b101 && d_instr[31:25] == 7'b0100000;

  AST_DECODE_VALID: assert property (@(posedge clk) disable iff (rst)
    (is_sll || is_srl || is_sra) |-> (valid_o && !illegal_o)); // R1
  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
    (reg_opc && !(is_sll || is_srl || is_sra)) |-> (illegal_o && !valid_o && result_o == '0)); // R2
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !reg_opc |-> (!illegal_o && !valid_o && result_o == '0)); // R3
  AST_NARROW_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !d_rv64 && d_rs2[4:0] == 5'd0) |->
      (result_o == {{HALF{d_rs1[HALF-1]}}, d_rs1[HALF-1:0]})); // R4
  AST_WIDE_LEFT_TOP: assert property (@(posedge clk) disable iff (rst)
    (is_sll && d_rv64 && d_rs2[5:0] == 6'd63) |->
      (result_o == {d_rs1[0], {(XLEN-1){1'b0}}})); // R5
  AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !d_rv64) |-> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}})); // R6
  AST_SRL_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
    (is_srl && !d_rv64 && d_rs2[4:0] != 5'd0) |-> (result_o == {{HALF{1'b0}}, 1'b0, result_o[HALF-2:0]})); // R7
  AST_SRA_SMEAR: assert property (@(posedge clk) disable iff (rst)
    (is_sra && !d_rv64 && d_rs1[HALF-1] && d_rs2[4:0] == 5'd31) |-> (result_o == '1)); // R8
  AST_SLL_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (is_sll && !d_rv64 && d_rs2[4:0] == 5'd31) |-> (result_o[HALF-2:0] == '0)); // R9
endmodule

bind shift_unit shift_unit_chk #(.XLEN(XLEN), .ILEN(ILEN), .REG_OUT(REG_OUT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .instr_i   (instr_i),
  .rs1_i     (rs1_i),
  .rs2_i     (rs2_i),
  .rv64_i    (rv64_i),
  .result_o  (result_o),
  .valid_o   (valid_o),
  .illegal_o (illegal_o)
);

// File: tb/shift_unit_tb_top.sv
`timescale 1ns/1ps
module shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        m64 = 1'b0;
  logic [63:0] res;
  logic        vld;
  logic        ill;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_unit dut_i (
    .clk(clk), .rst(rst), .instr_i(instr), .rs1_i(a), .rs2_i(b),
    .rv64_i(m64), .result_o(res), .valid_o(vld), .illegal_o(ill)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  // op: 0 left, 1 logical right, 2 arithmetic right
  function automatic logic [63:0] model(input int op, input bit w, input logic [63:0] x, input logic [63:0] y);
    logic [31:0] r32;
    logic [63:0] r64;
    if (w) begin
      case (op)
        0: r64 = x << y[5:0];
        1: r64 = x >> y[5:0];
        default: r64 = 64'($signed(x) >>> y[5:0]);
      endcase
      return r64;
    end
    case (op)
      0: r32 = x[31:0] << y[4:0];
      1: r32 = x[31:0] >> y[4:0];
      default: r32 = 32'($signed(x[31:0]) >>> y[4:0]);
    endcase
    return {{32{r32[31]}}, r32};
  endfunction

  task automatic compare(input string tag, input logic [63:0] er, input bit ev, input bit ei);
    n_cmp++;
    if (res !== er || vld !== ev || ill !== ei) begin
      n_bad++;
      $display("FAIL %s: got res=%h v=%b i=%b exp res=%h v=%b i=%b", tag, res, vld, ill, er, ev, ei);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [63:0] x, input logic [63:0] y, input bit w,
                     input logic [63:0] er, input bit ev, input bit ei, input string tag);
    @(negedge clk);
    instr = ins; a = x; b = y; m64 = w;
    @(posedge clk);
    #1;
    compare(tag, er, ev, ei);
  endtask

  logic [31:0] enc [3];
  logic [63:0] pats [6];

  initial begin
    enc[0] = mk(7'b0000000, 3'b001, 7'b0110011);
    enc[1] = mk(7'b0000000, 3'b101, 7'b0110011);
    enc[2] = mk(7'b0100000, 3'b101, 7'b0110011);
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h8000_0000_0000_0001;
    pats[2] = 64'h0000_0000_8000_0000;
    pats[3] = 64'h1234_5678_9ABC_DEF0;
    pats[4] = 64'h7FFF_FFFF_4000_0000;
    pats[5] = 64'h0000_0000_0000_0001;

    // R10: reset dominates a legal request
    repeat (2) @(posedge clk);
    run(enc[0], 64'hFF, 64'd1, 1'b1, 64'd0, 1'b0, 1'b0, "R10 reset");
    @(negedge clk);
    rst = 1'b0;

    // R10: one-edge latency after reset release
    run(enc[0], 64'h1, 64'd4, 1'b1, 64'h10, 1'b1, 1'b0, "R10 R1 latency");

    // Directed examples
    run(enc[1], 64'hFFFF_FFFF, 64'd1, 1'b0, 64'h7FFF_FFFF, 1'b1, 1'b0, "R7 srl zero fill");
    run(enc[2], 64'h8000_0000, 64'd31, 1'b0, '1, 1'b1, 1'b0, "R8 sra smear");
    run(enc[2], 64'hFFFF_FFFF, 64'd33, 1'b0, '1, 1'b1, 1'b0, "R8 R4 sra 33");
    run(enc[0], 64'hFFFF_FFFF, 64'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, "R9 sll overflow");
    run(enc[0], 64'h1, 64'd63, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, "R4 R6 sll 63");
    run(enc[0], 64'h2D, 64'd32, 1'b0, 64'h2D, 1'b1, 1'b0, "R4 sll 32");
    run(enc[1], 64'h8000_0000, 64'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, "R6 srl sext");
    run(enc[2], 64'h4000_0000, 64'd37, 1'b0, 64'h0200_0000, 1'b1, 1'b0, "R4 sra 37");
    run(enc[2], 64'h8000_0000_0000_0000, 64'd63, 1'b1, '1, 1'b1, 1'b0, "R5 R8 wide sra");
    run(enc[1], 64'h8000_0000_0000_0000, 64'd63, 1'b1, 64'h1, 1'b1, 1'b0, "R5 R7 wide srl");

    // Sweep: every mode, operation, amount and operand pattern
    for (int w = 0; w < 2; w++)
      for (int op = 0; op < 3; op++)
        for (int s = 0; s < 64; s++)
          for (int p = 0; p < 7; p++) begin
            logic [63:0] x;
            logic [63:0] y;
            string tg;
            x = (p < 6) ? pats[p] : {$urandom, $urandom};
            y = {$urandom, $urandom};
            y[5:0] = 6'(s);
            tg = $sformatf("%s %s s=%0d", w ? "R5" : "R4 R6",
                           op == 0 ? "R9" : (op == 1 ? "R7" : "R8"), s);
            run(enc[op], x, y, w[0], model(op, w[0], x, y), 1'b1, 1'b0, tg);
          end

    // Decode sweep under the register opcode
    for (int f3 = 0; f3 < 8; f3++)
      for (int k = 0; k < 5; k++) begin
        logic [6:0] f7;
        bit ok;
        int op;
        logic [63:0] x;
        f7 = (k == 0) ? 7'h00 : (k == 1) ? 7'h20 : (k == 2) ? 7'h01 : (k == 3) ? 7'h40 : 7'h7F;
        ok = (f3 == 1 && f7 == 7'h00) || (f3 == 5 && (f7 == 7'h00 || f7 == 7'h20));
        op = (f3 == 1) ? 0 : (f7 == 7'h20 ? 2 : 1);
        x = {$urandom, $urandom};
        run(mk(f7, 3'(f3), 7'b0110011), x, 64'd3, 1'b1,
            ok ? model(op, 1'b1, x, 64'd3) : 64'd0, ok, !ok, ok ? "R1 decode" : "R2 reserved");
      end

    // Other major opcodes carrying shift-like fields
    run(mk(7'h00, 3'b001, 7'b0010011), '1, 64'd1, 1'b1, 64'd0, 1'b0, 1'b0, "R3 imm opcode");
    run(mk(7'h20, 3'b101, 7'b0111011), '1, 64'd1, 1'b0, 64'd0, 1'b0, 1'b0, "R3 word opcode");
    run(mk(7'h00, 3'b101, 7'b0000000), '1, 64'd1, 1'b1, 64'd0, 1'b0, 1'b0, "R3 zero opcode");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule